// File: doc/BRIEF.md
# DMA Address Translation Unit

This block maps the bus addresses that devices issue for DMA onto system physical addresses. It keeps a single-level table of 64-bit translation entries in internal storage, one entry per page. The size of a page is set by a shift parameter and the number of entries by a depth parameter. The table therefore covers a window of `DEPTH << PAGE_SHIFT` bytes that starts at bus address zero. Each entry holds a physical page address in its upper bits and a two-bit access code in its lowest bits. Software loads entries through a one-cycle update port.

A lookup is one request beat that carries a bus address and a read/write flag. One cycle after the request is accepted, the unit returns a single response beat. The beat holds the page-aligned input address, the translated page address, the in-page offset mask, the access code of the entry and a fault flag. The fault flag is set when the access code does not permit the requested direction. An address beyond the table window does not produce an error: it returns a no-access result. Synchronous reset clears every entry, so every page starts with no access.

Top module: `iommu_xlate`

## Requirements
- R1: The table index is `req_addr >> PAGE_SHIFT`. For an index below DEPTH, `rsp_paddr` is the stored entry with bits `[PAGE_SHIFT-1:0]` forced to zero.
- R2: For an index below DEPTH, `rsp_iova` is `req_addr` with bits `[PAGE_SHIFT-1:0]` cleared, and `rsp_mask` is `(1 << PAGE_SHIFT) - 1`.
- R3: For an index of DEPTH or more, the response has `rsp_perm` = 0, `rsp_paddr` = 0, `rsp_iova` = 0 and `rsp_mask` all ones.
- R4: For an in-range index, `rsp_perm` equals bits `[1:0]` of the entry. The encoding is 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R5: `rsp_fault` is 1 when `req_write` = 1 and `rsp_perm[1]` = 0. It is also 1 when `req_write` = 0 and `rsp_perm[0]` = 0. Otherwise it is 0.
- R6: After reset, `rsp_valid` is 0, `req_ready` is 1, and every in-range lookup returns `rsp_perm` = 0 and `rsp_paddr` = 0.
- R7: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) makes `rsp_valid` 1 after that edge. The response holds all of its fields unchanged while `rsp_ready` is 0. `req_ready` equals `!rsp_valid || rsp_ready`, so a stream with `rsp_ready` held at 1 completes one lookup per cycle.
- R8: With `upd_en` = 1, `upd_entry` is written to entry `upd_idx`. The new value is seen by any request accepted on a later edge. A request accepted on the same edge sees the old value. An update whose `upd_idx` is DEPTH or more changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W | Device bus address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_iova | output | ADDR_W | Page-aligned input address |
| rsp_paddr | output | ENTRY_W | Translated page address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Access code of the entry |
| rsp_fault | output | 1 | Requested direction not permitted |
| upd_en | input | 1 | Write one table entry |
| upd_idx | input | ADDR_W-PAGE_SHIFT | Entry number to write |
| upd_entry | input | ENTRY_W | Entry value |

## Verification
The bench aims at addresses on both sides of the window edge. An off-by-one bound would translate index DEPTH through a wrapped entry, or would treat the last entry as outside the window. It writes entries with all four access codes and looks each one up for both reads and writes. Swapped code bits would show up as a fault on a permitted access. Updates to indices just past the window check for aliasing, since a truncated index would overwrite a low entry. Stalled responses, back-to-back streams and a lookup in the same cycle as an update expose a response that drifts while it is held, a lost beat, or a write that takes effect too early.

// File: rtl/iommu_xlate.sv
module iommu_xlate #(
  parameter int ADDR_W     = 32,
  parameter int ENTRY_W    = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int DEPTH      = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [ADDR_W-1:0]        rsp_iova,
  output logic [ENTRY_W-1:0]       rsp_paddr,
  output logic [ADDR_W-1:0]        rsp_mask,
  output logic [1:0]               rsp_perm,
  output logic                     rsp_fault,
  input  logic                     upd_en,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] upd_idx,
  input  logic [ENTRY_W-1:0]       upd_entry
);
  localparam int IDX_W = ADDR_W - PAGE_SHIFT;
  localparam int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0]   DEPTH_I  = IDX_W'(DEPTH);
  localparam logic [ADDR_W-1:0]  OFF_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);
  localparam logic [ENTRY_W-1:0] ENT_OFF  = (ENTRY_W'(1) << PAGE_SHIFT) - ENTRY_W'(1);

  logic [ENTRY_W-1:0] tab [DEPTH];

  logic [IDX_W-1:0] idx;
  logic             hit, upd_hit, fire;
  logic [ENTRY_W-1:0] ent;
  logic             wr_q;

  assign idx     = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign hit     = idx < DEPTH_I;
  assign upd_hit = upd_idx < DEPTH_I;
  assign ent     = hit ? tab[idx[TW-1:0]] : '0;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rsp_fault = wr_q ? !rsp_perm[1] : !rsp_perm[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
    end else if (upd_en && upd_hit) begin
      tab[upd_idx[TW-1:0]] <= upd_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_iova  <= '0;
      rsp_paddr <= '0;
      rsp_mask  <= '0;
      rsp_perm  <= '0;
      wr_q      <= 1'b0;
    end else begin
      if (fire) begin
        rsp_valid <= 1'b1;
        rsp_iova  <= hit ? (req_addr & ~OFF_MASK) : '0;
        rsp_paddr <= ent & ~ENT_OFF;
        rsp_mask  <= hit ? OFF_MASK : '1;
        rsp_perm  <= ent[1:0];
        wr_q      <= req_write;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R7
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_iova)
      && $stable(rsp_mask) && $stable(rsp_perm) && $stable(rsp_fault));

  // R1
  paddr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_paddr & ENT_OFF) == '0);

  // R2
  iova_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_iova & rsp_mask) == '0);

  // R3
  miss_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_mask == '1) |-> rsp_perm == 2'd0 && rsp_paddr == '0);

  // R5
  no_access_faults_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_perm == 2'd0 |-> rsp_fault);
endmodule

// File: tb/tb_iommu_xlate.sv
module tb_iommu_xlate;
  localparam int AW = 32, EW = 64, PS = 12, DEPTH = 16, IW = AW - PS;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, rsp_ready = 0, upd_en = 0;
  logic [AW-1:0] req_addr = '0;
  logic [IW-1:0] upd_idx = '0;
  logic [EW-1:0] upd_entry = '0;
  logic req_ready, rsp_valid, rsp_fault;
  logic [AW-1:0] rsp_iova, rsp_mask;
  logic [EW-1:0] rsp_paddr;
  logic [1:0] rsp_perm;

  iommu_xlate #(.ADDR_W(AW), .ENTRY_W(EW), .PAGE_SHIFT(PS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_paddr(rsp_paddr),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_entry(upd_entry));

  always #5ns clk = ~clk;

  int unsigned nchk = 0, nfail = 0;
  logic [EW-1:0] model [DEPTH];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [AW-1:0] iova;
    logic [EW-1:0] paddr;
    logic [AW-1:0] mask;
    logic [1:0]    perm;
    logic          fault;
  } rsp_t;

  function automatic rsp_t predict(input logic [AW-1:0] a, input logic wr);
    rsp_t r;
    logic [AW-1:0] pg = (AW'(1) << PS) - AW'(1);
    logic [EW-1:0] e;
    if ((a >> PS) < DEPTH) begin
      e = model[a >> PS];
      r.iova = a & ~pg;
      r.paddr = e & ~((EW'(1) << PS) - EW'(1));
      r.mask = pg;
      r.perm = e[1:0];
    end else begin
      r.iova = '0; r.paddr = '0; r.mask = '1; r.perm = 2'd0;
    end
    r.fault = wr ? !r.perm[1] : !r.perm[0];
    return r;
  endfunction

  task automatic cmp(input string tag, input rsp_t e);
    chk({tag, " R1 paddr"}, rsp_paddr, e.paddr);
    chk({tag, " R2/R3 iova"}, 64'(rsp_iova), 64'(e.iova));
    chk({tag, " R2/R3 mask"}, 64'(rsp_mask), 64'(e.mask));
    chk({tag, " R4 perm"}, 64'(rsp_perm), 64'(e.perm));
    chk({tag, " R5 fault"}, 64'(rsp_fault), 64'(e.fault));
  endtask

  task automatic upd(input logic [IW-1:0] i, input logic [EW-1:0] v);
    @(negedge clk);
    upd_en = 1; upd_idx = i; upd_entry = v;
    @(negedge clk);
    upd_en = 0;
    if (i < DEPTH) model[i] = v;
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic wr, input int stall, input string tag);
    rsp_t e;
    @(negedge clk);
    chk({tag, " R7 ready idle"}, 64'(req_ready), 64'd1);
    req_valid = 1; req_addr = a; req_write = wr; rsp_ready = 0;
    @(negedge clk);
    req_valid = 0;
    e = predict(a, wr);
    chk({tag, " R7 valid"}, 64'(rsp_valid), 64'd1);
    cmp(tag, e);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk({tag, " R7 held valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " R7 ready low"}, 64'(req_ready), 64'd0);
      cmp({tag, " R7 held"}, e);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk({tag, " R7 drained"}, 64'(rsp_valid), 64'd0);
    rsp_ready = 0;
  endtask

  initial begin
    #2ms;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int unsigned sd;
    logic [AW-1:0] a;
    rsp_t pend;
    sd = $urandom(32'd20240607);
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R6 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R6 req_ready after reset", 64'(req_ready), 64'd1);
    for (int i = 0; i < DEPTH; i++) lookup(AW'(i) << PS | AW'(i * 37), i[0], 0, "R6 cleared");

    // every access code, both directions
    for (int c = 0; c < 4; c++) upd(IW'(c), {$urandom, $urandom} & ~64'h3 | 64'(c));
    for (int c = 0; c < 4; c++) begin
      lookup(AW'(c) << PS | 32'h5a5, 1'b0, 0, "R4 code read");
      lookup(AW'(c) << PS | 32'h0ff, 1'b1, 1, "R5 code write");
    end

    // window edges
    upd(IW'(DEPTH - 1), 64'hdead_beef_cafe_f003);
    lookup((AW'(DEPTH) << PS) - 1, 1'b1, 0, "R1 last page top");
    lookup(AW'(DEPTH) << PS, 1'b0, 0, "R3 first out");
    lookup(32'hffff_ffff, 1'b1, 2, "R3 top of space");

    // out-of-window updates must not alias
    upd(IW'(DEPTH + 3), 64'h1111_2222_3333_4447);
    upd(IW'(2 * DEPTH), 64'h9999_8888_7777_6663);
    lookup(AW'(3) << PS, 1'b0, 0, "R8 no alias 3");
    lookup(AW'(0) << PS, 1'b1, 0, "R8 no alias 0");

    // update and lookup on the same edge: old value, then new
    @(negedge clk);
    upd_en = 1; upd_idx = IW'(5); upd_entry = 64'h0123_4567_89ab_c003;
    req_valid = 1; req_addr = AW'(5) << PS | 32'h10; req_write = 1; rsp_ready = 0;
    pend = predict(req_addr, 1'b1);
    @(negedge clk);
    upd_en = 0; req_valid = 0;
    model[5] = 64'h0123_4567_89ab_c003;
    cmp("R8 same-edge old", pend);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    lookup(AW'(5) << PS | 32'h10, 1'b1, 0, "R8 next new");

    // random table contents and a streamed run of lookups
    for (int k = 0; k < 40; k++) upd(IW'($urandom_range(DEPTH + 4)), {$urandom, $urandom});
    rsp_ready = 1;
    for (int k = 0; k <= 200; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R7 stream valid", 64'(rsp_valid), 64'd1);
        cmp("R7 stream", pend);
      end
      if (k < 200) begin
        a = $urandom;
        if ($urandom_range(1) == 0) a = a & ((AW'(DEPTH) << (PS + 1)) - 1);
        req_valid = 1; req_addr = a; req_write = $urandom_range(1) == 1;
        pend = predict(a, req_write);
      end else req_valid = 0;
    end
    @(negedge clk);
    chk("R7 stream drained", 64'(rsp_valid), 64'd0);
    rsp_ready = 0;
    for (int k = 0; k < 20; k++)
      lookup($urandom & ((AW'(DEPTH) << (PS + 1)) - 1), $urandom_range(1) == 1,
             $urandom_range(2), "R1 random stalled");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule